// File: doc/BRIEF.md
# Bridge Exclusive-Access Lock Controller

This block follows exclusive (locked) access while a bus bridge forwards transactions from an initiator bus to a target bus. It does not model bus cycles. It works on a few event inputs:

- the sampled initiator lock and frame levels;
- a pulse that marks the start of a locked transaction, with its direction and its kind (delayed or posted write);
- a completion pulse from the target side, carrying a result code.

From these it drives four things: the target-side lock line (active low), a level that stops unlocked forwarding while the lock is held, an abort code that is handed back when the initiator repeats an aborted transaction, and an active-low system-error pulse. It also keeps two sticky abort status bits, which a write-one-to-clear strobe resets.

Whether the lock is held depends on three things: where a transaction sits in the locked sequence, whether it is delayed or posted, and which way it goes. The release of the lock is seen lazily. After the initiator drops its lock while the frame is idle, the target lock stays asserted for `REL_GAP` more cycles. A locked start that arrives inside that window is parked and launched once the target lock has dropped.

Top module: `lk_bridge_lock`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, the outputs are `tgt_lock_n`=1, `fwd_block`=0, `serr_n`=1, `abort_ret_vld`=0, `sts_tabt`=0 and `sts_mabt`=0.
- R2: A `lk_start` with `lk_down`=1 in the idle state drives `tgt_lock_n` low and `fwd_block` high from the next cycle on.
- R3: A `tgt_done` with `tgt_result`=2'b01 (retry) on the first transaction of a sequence releases the target lock in the next cycle. A retry on any later transaction of the sequence leaves the target lock asserted.
- R4: Once the lock is held, the initiator has released it when `init_lock_n`=1 and `init_frame_n`=1 with no transaction in flight. `tgt_lock_n` then stays low for exactly `REL_GAP` more cycles and goes high after that.
- R5: A posted-write completion with a result other than retry, arriving while `init_lock_n`=1, releases the target lock in the next cycle.
- R6: A delayed transaction that completes with target abort (2'b10) or master abort (2'b11) is parked. On the next `repeat_req`, `abort_ret_vld` is 1 in that same cycle and `abort_code` equals the result received. After that, `init_lock_n`=1 with `init_frame_n`=1 ends the lock.
- R7: When the first delayed transaction of a sequence aborts, the target lock and `fwd_block` drop in the next cycle. They are not held while the abort code waits to be returned.
- R8: A posted write that completes with either abort code drives `serr_n` low for exactly one cycle, in the cycle after the completion. The lock state is unchanged unless R5 also applies.
- R9: `sts_tabt` and `sts_mabt` are set one cycle after a target abort or master abort completes. They stay set until `sts_clr[0]` (for `sts_tabt`) or `sts_clr[1]` (for `sts_mabt`) is pulsed. A set in the same cycle wins over a clear.
- R10: A downstream `lk_start` that arrives during the release window is held. It starts a new lock one cycle after `tgt_lock_n` has gone high.
- R11: A `lk_start` with `lk_down`=0 (upstream) changes nothing: the target lock stays deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_lock_n | input | 1 | Sampled initiator lock level, active low |
| init_frame_n | input | 1 | Sampled initiator frame level, active low |
| lk_start | input | 1 | Pulse: a locked transaction starts |
| lk_down | input | 1 | Direction of that start: 1 = downstream, 0 = upstream |
| lk_posted | input | 1 | Kind of that start: 1 = posted write, 0 = delayed |
| tgt_done | input | 1 | Pulse: the target side finished the transaction in flight |
| tgt_result | input | 2 | 00 normal, 01 retry, 10 target abort, 11 master abort |
| repeat_req | input | 1 | Pulse: the initiator repeats the parked transaction |
| sts_clr | input | 2 | Write-one-to-clear strobe: bit 0 for the target-abort bit, bit 1 for the master-abort bit |
| tgt_lock_n | output | 1 | Target-side lock, active low |
| fwd_block | output | 1 | High while unlocked forwarding must wait |
| abort_ret_vld | output | 1 | The abort code is being returned to the initiator |
| abort_code | output | 2 | Abort result to return (10 or 11) |
| serr_n | output | 1 | One-cycle system-error pulse, active low |
| sts_tabt | output | 1 | Sticky bit: target abort received |
| sts_mabt | output | 1 | Sticky bit: master abort received |

## Verification
The bench drives several kinds of locked sequence:

- a sequence that ends in a delayed release;
- one that ends in a posted write;
- a retry on the first transaction, and a retry on a later one;
- a delayed abort on the first transaction, and on a later one;
- a posted-write abort;
- a start that lands inside the release window.

The first-versus-later retry pair separates position-dependent lock ownership from a plain retry rule. The two delayed-abort cases separate releasing the lock at once from holding it while the code is parked. The posted ending and the lazy ending differ in how many cycles the target lock stays low, which checks the `REL_GAP` window. An upstream start and a clear strobe, each placed between other sequences, show that these inputs touch only what the requirements allow.

// File: rtl/lk_pkg.sv
package lk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PEND   = 3'd1,
    ST_LOCKED = 3'd2,
    ST_ABORT  = 3'd3,
    ST_REL    = 3'd4
  } lk_state_e;

  localparam logic [1:0] RES_OK    = 2'b00;
  localparam logic [1:0] RES_RETRY = 2'b01;
  localparam logic [1:0] RES_TABT  = 2'b10;
  localparam logic [1:0] RES_MABT  = 2'b11;

  // Both abort codes have the upper bit set.
  function automatic logic res_is_abort(input logic [1:0] r);
    return r[1];
  endfunction

  // The initiator has let go: lock and frame are both idle (high).
  function automatic logic init_released(input logic lock_n, input logic frame_n);
    return lock_n & frame_n;
  endfunction

  // States in which the target-side lock is driven.
  function automatic logic lock_held(input lk_state_e st, input logic ab_first);
    case (st)
      ST_PEND, ST_LOCKED, ST_REL: return 1'b1;
      ST_ABORT:                   return ~ab_first;
      default:                    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lk_release_timer.sv
module lk_release_timer #(
  parameter int unsigned REL_GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int unsigned CW = (REL_GAP < 2) ? 1 : $clog2(REL_GAP);

  generate
    if (REL_GAP <= 1) begin : g_immediate
      assign done = active;
    end else begin : g_count
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!active) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end

      assign done = active && (cnt_q == CW'(REL_GAP - 1));
    end
  endgenerate
endmodule

// File: rtl/lk_status.sv
module lk_status
  import lk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_posted_abort,
  input  logic       ev_delayed_abort,
  input  logic [1:0] tgt_result,
  input  logic [1:0] sts_clr,
  output logic       sts_tabt,
  output logic       sts_mabt,
  output logic       serr_n
);
  logic any_abort, set_ta, set_ma;

  always_comb begin
    any_abort = ev_posted_abort | ev_delayed_abort;
    set_ta    = any_abort && (tgt_result == RES_TABT);
    set_ma    = any_abort && (tgt_result == RES_MABT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_tabt <= 1'b0;
      sts_mabt <= 1'b0;
      serr_n   <= 1'b1;
    end else begin
      sts_tabt <= set_ta | (sts_tabt & ~sts_clr[0]);
      sts_mabt <= set_ma | (sts_mabt & ~sts_clr[1]);
      serr_n   <= ~ev_posted_abort;
    end
  end
endmodule

// File: rtl/lk_fsm.sv
module lk_fsm
  import lk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_lock_n,
  input  logic       init_frame_n,
  input  logic       lk_start,
  input  logic       lk_down,
  input  logic       lk_posted,
  input  logic       tgt_done,
  input  logic [1:0] tgt_result,
  input  logic       repeat_req,
  input  logic       rel_done,
  output lk_state_e  state_o,
  output logic       ab_first_o,
  output logic [1:0] ab_code_o,
  output logic       ab_given_o,
  output logic       pend_o,
  output logic       ev_acquire,
  output logic       ev_first_retry,
  output logic       ev_posted_end,
  output logic       ev_posted_abort,
  output logic       ev_delayed_abort,
  output logic       ev_rel_seen,
  output logic       ev_held
);
  lk_state_e  state_q;
  logic       busy_q, cur_posted_q, ab_first_q, ab_given_q;
  logic [1:0] ab_code_q;
  logic       pend_q, pend_posted_q;

  logic start_dn, released, in_flight, done_here, is_abt;

  always_comb begin
    start_dn  = lk_start & lk_down;
    released  = init_released(init_lock_n, init_frame_n);
    in_flight = (state_q == ST_PEND) || ((state_q == ST_LOCKED) && busy_q);
    done_here = tgt_done & in_flight;
    is_abt    = res_is_abort(tgt_result);

    ev_acquire       = (state_q == ST_IDLE) && (start_dn || pend_q);
    ev_first_retry   = (state_q == ST_PEND) && tgt_done && (tgt_result == RES_RETRY);
    ev_posted_abort  = done_here && cur_posted_q && is_abt;
    ev_delayed_abort = done_here && !cur_posted_q && is_abt;
    ev_posted_end    = done_here && cur_posted_q && init_lock_n && (tgt_result != RES_RETRY);
    ev_rel_seen      = (state_q == ST_LOCKED) && !busy_q && !start_dn && released;
    ev_held          = (state_q == ST_REL) && start_dn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      busy_q        <= 1'b0;
      cur_posted_q  <= 1'b0;
      ab_first_q    <= 1'b0;
      ab_given_q    <= 1'b0;
      ab_code_q     <= RES_OK;
      pend_q        <= 1'b0;
      pend_posted_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ev_acquire) begin
            state_q      <= ST_PEND;
            cur_posted_q <= pend_q ? pend_posted_q : lk_posted;
            pend_q       <= 1'b0;
          end
        end
        ST_PEND: begin
          if (tgt_done) begin
            if (tgt_result == RES_RETRY) begin
              state_q <= ST_IDLE;
            end else if (ev_delayed_abort) begin
              state_q    <= ST_ABORT;
              ab_first_q <= 1'b1;
              ab_code_q  <= tgt_result;
              ab_given_q <= 1'b0;
            end else if (ev_posted_end) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_LOCKED;
              busy_q  <= 1'b0;
            end
          end
        end
        ST_LOCKED: begin
          if (start_dn && !busy_q) begin
            busy_q       <= 1'b1;
            cur_posted_q <= lk_posted;
          end else if (done_here) begin
            busy_q <= 1'b0;
            if (ev_delayed_abort) begin
              state_q    <= ST_ABORT;
              ab_first_q <= 1'b0;
              ab_code_q  <= tgt_result;
              ab_given_q <= 1'b0;
            end else if (ev_posted_end) begin
              state_q <= ST_IDLE;
            end
          end else if (ev_rel_seen) begin
            state_q <= ST_REL;
          end
        end
        ST_ABORT: begin
          if (!ab_given_q && repeat_req) begin
            ab_given_q <= 1'b1;
          end else if (ab_given_q && released) begin
            state_q <= ab_first_q ? ST_IDLE : ST_REL;
          end
        end
        ST_REL: begin
          if (ev_held) begin
            pend_q        <= 1'b1;
            pend_posted_q <= lk_posted;
          end
          if (rel_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign ab_first_o = ab_first_q;
  assign ab_code_o  = ab_code_q;
  assign ab_given_o = ab_given_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/lk_bridge_lock.sv
module lk_bridge_lock
  import lk_pkg::*;
#(
  parameter int unsigned REL_GAP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_lock_n,
  input  logic       init_frame_n,
  input  logic       lk_start,
  input  logic       lk_down,
  input  logic       lk_posted,
  input  logic       tgt_done,
  input  logic [1:0] tgt_result,
  input  logic       repeat_req,
  input  logic [1:0] sts_clr,
  output logic       tgt_lock_n,
  output logic       fwd_block,
  output logic       abort_ret_vld,
  output logic [1:0] abort_code,
  output logic       serr_n,
  output logic       sts_tabt,
  output logic       sts_mabt
);
  lk_state_e  state;
  logic       ab_first, ab_given, pend;
  logic [1:0] ab_code;
  logic       rel_done;
  logic       ev_acquire, ev_first_retry, ev_posted_end;
  logic       ev_posted_abort, ev_delayed_abort, ev_rel_seen, ev_held;

  lk_fsm u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .init_lock_n      (init_lock_n),
    .init_frame_n     (init_frame_n),
    .lk_start         (lk_start),
    .lk_down          (lk_down),
    .lk_posted        (lk_posted),
    .tgt_done         (tgt_done),
    .tgt_result       (tgt_result),
    .repeat_req       (repeat_req),
    .rel_done         (rel_done),
    .state_o          (state),
    .ab_first_o       (ab_first),
    .ab_code_o        (ab_code),
    .ab_given_o       (ab_given),
    .pend_o           (pend),
    .ev_acquire       (ev_acquire),
    .ev_first_retry   (ev_first_retry),
    .ev_posted_end    (ev_posted_end),
    .ev_posted_abort  (ev_posted_abort),
    .ev_delayed_abort (ev_delayed_abort),
    .ev_rel_seen      (ev_rel_seen),
    .ev_held          (ev_held)
  );

  lk_release_timer #(.REL_GAP(REL_GAP)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state == ST_REL),
    .done   (rel_done)
  );

  lk_status u_status (
    .clk              (clk),
    .rst_n            (rst_n),
    .ev_posted_abort  (ev_posted_abort),
    .ev_delayed_abort (ev_delayed_abort),
    .tgt_result       (tgt_result),
    .sts_clr          (sts_clr),
    .sts_tabt         (sts_tabt),
    .sts_mabt         (sts_mabt),
    .serr_n           (serr_n)
  );

  always_comb begin
    tgt_lock_n    = ~lock_held(state, ab_first);
    fwd_block     = lock_held(state, ab_first);
    abort_ret_vld = (state == ST_ABORT) && repeat_req && !ab_given;
    abort_code    = ab_code;
  end
endmodule

// File: rtl/lk_bridge_lock_chk.sv
module lk_bridge_lock_chk
  import lk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       lk_start,
  input logic       lk_down,
  input logic       tgt_done,
  input logic [1:0] tgt_result,
  input logic [1:0] sts_clr,
  input lk_state_e  state,
  input logic       rel_done,
  input logic       pend,
  input logic       tgt_lock_n,
  input logic       fwd_block,
  input logic       abort_ret_vld,
  input logic [1:0] abort_code,
  input logic       serr_n,
  input logic       sts_tabt,
  input logic       sts_mabt,
  input logic       ev_acquire,
  input logic       ev_first_retry,
  input logic       ev_posted_end,
  input logic       ev_posted_abort,
  input logic       ev_delayed_abort
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tgt_lock_n && !fwd_block && serr_n && !sts_tabt && !sts_mabt));

  p_acquire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_acquire |=> (!tgt_lock_n && fwd_block));

  p_first_retry_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first_retry |=> tgt_lock_n);

  p_later_retry_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCKED && tgt_done && tgt_result == RES_RETRY) |=> !tgt_lock_n);

  p_release_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REL && rel_done) |=> tgt_lock_n);

  p_posted_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_posted_end |=> tgt_lock_n);

  p_abort_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ret_vld |-> abort_code[1]);

  p_first_abort_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_delayed_abort && state == ST_PEND) |=> (tgt_lock_n && !fwd_block));

  p_serr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_posted_abort |=> !serr_n);

  p_serr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |=> serr_n);

  p_sticky_ta_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_tabt && !sts_clr[0]) |=> sts_tabt);

  p_sticky_ma_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_mabt && !sts_clr[1]) |=> sts_mabt);

  p_held_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && pend) |=> !tgt_lock_n);

  p_upstream_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_lock_n && lk_start && !lk_down && !ev_acquire) |=> tgt_lock_n);
endmodule

bind lk_bridge_lock lk_bridge_lock_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .lk_start         (lk_start),
  .lk_down          (lk_down),
  .tgt_done         (tgt_done),
  .tgt_result       (tgt_result),
  .sts_clr          (sts_clr),
  .state            (state),
  .rel_done         (rel_done),
  .pend             (pend),
  .tgt_lock_n       (tgt_lock_n),
  .fwd_block        (fwd_block),
  .abort_ret_vld    (abort_ret_vld),
  .abort_code       (abort_code),
  .serr_n           (serr_n),
  .sts_tabt         (sts_tabt),
  .sts_mabt         (sts_mabt),
  .ev_acquire       (ev_acquire),
  .ev_first_retry   (ev_first_retry),
  .ev_posted_end    (ev_posted_end),
  .ev_posted_abort  (ev_posted_abort),
  .ev_delayed_abort (ev_delayed_abort)
);

// File: tb/test_lk_bridge_lock.sv
`timescale 1ns/1ps
module test_lk_bridge_lock;
  localparam int GAP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_lock_n = 1'b1, init_frame_n = 1'b1;
  logic       lk_start = 1'b0, lk_down = 1'b0, lk_posted = 1'b0;
  logic       tgt_done = 1'b0;
  logic [1:0] tgt_result = 2'b00;
  logic       repeat_req = 1'b0;
  logic [1:0] sts_clr = 2'b00;
  logic       tgt_lock_n, fwd_block, abort_ret_vld, serr_n, sts_tabt, sts_mabt;
  logic [1:0] abort_code;

  always #10 clk = ~clk;

  lk_bridge_lock #(.REL_GAP(GAP)) i_lk_bridge_lock (
    .clk(clk), .rst_n(rst_n), .init_lock_n(init_lock_n), .init_frame_n(init_frame_n),
    .lk_start(lk_start), .lk_down(lk_down), .lk_posted(lk_posted),
    .tgt_done(tgt_done), .tgt_result(tgt_result), .repeat_req(repeat_req),
    .sts_clr(sts_clr), .tgt_lock_n(tgt_lock_n), .fwd_block(fwd_block),
    .abort_ret_vld(abort_ret_vld), .abort_code(abort_code), .serr_n(serr_n),
    .sts_tabt(sts_tabt), .sts_mabt(sts_mabt)
  );

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    finished = 1'b0;

  // Reference model: 0 idle, 1 first in flight, 2 held, 3 abort parked, 4 releasing
  int m_st = 0, m_cnt = 0;
  bit m_busy, m_post, m_abf, m_given, m_pend, m_ppost;
  bit m_serr = 1'b1, m_ta, m_ma;
  int m_code;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_busy = 0; m_post = 0; m_abf = 0; m_given = 0;
      m_pend = 0; m_ppost = 0; m_serr = 1; m_ta = 0; m_ma = 0; m_code = 0;
      cmp_on = 1'b1;
    end else begin
      bit dn, rel, live, fin, abt, tdone;
      int old_st;
      old_st = m_st;
      dn    = lk_start && lk_down;
      rel   = init_lock_n && init_frame_n;
      live  = (m_st == 1) || (m_st == 2 && m_busy);
      fin   = tgt_done && live;
      abt   = tgt_result >= 2;
      m_serr = !(fin && m_post && abt);
      if (fin && tgt_result == 2) m_ta = 1; else if (sts_clr[0]) m_ta = 0;
      if (fin && tgt_result == 3) m_ma = 1; else if (sts_clr[1]) m_ma = 0;
      tdone = (m_st == 4) && (m_cnt == GAP - 1);
      if (old_st == 0) begin
        if (dn || m_pend) begin m_st = 1; m_post = m_pend ? m_ppost : lk_posted; m_pend = 0; end
      end else if (old_st == 1) begin
        if (tgt_done) begin
          if (tgt_result == 1) m_st = 0;
          else if (!m_post && abt) begin m_st = 3; m_abf = 1; m_code = tgt_result; m_given = 0; end
          else if (m_post && init_lock_n) m_st = 0;
          else begin m_st = 2; m_busy = 0; end
        end
      end else if (old_st == 2) begin
        if (dn && !m_busy) begin m_busy = 1; m_post = lk_posted; end
        else if (fin) begin
          m_busy = 0;
          if (!m_post && abt) begin m_st = 3; m_abf = 0; m_code = tgt_result; m_given = 0; end
          else if (m_post && init_lock_n && tgt_result != 1) m_st = 0;
        end else if (!m_busy && rel) m_st = 4;
      end else if (old_st == 3) begin
        if (!m_given && repeat_req) m_given = 1;
        else if (m_given && rel) m_st = m_abf ? 0 : 4;
      end else begin
        if (dn) begin m_pend = 1; m_ppost = lk_posted; end
        if (tdone) m_st = 0;
      end
      if (old_st == 4) m_cnt = m_cnt + 1; else m_cnt = 0;
      if (m_st != 4) m_cnt = 0;
    end
  end

  task automatic chk(string what, int got, int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_on && !finished) begin
      bit held, vld;
      held = (m_st == 1) || (m_st == 2) || (m_st == 4) || (m_st == 3 && !m_abf);
      vld  = (m_st == 3) && repeat_req && !m_given;
      chk("tgt_lock_n", tgt_lock_n, !held);
      chk("fwd_block", fwd_block, held);
      chk("abort_ret_vld", abort_ret_vld, vld);
      if (vld) chk("abort_code", abort_code, m_code);
      chk("serr_n", serr_n, m_serr);
      chk("sts_tabt", sts_tabt, m_ta);
      chk("sts_mabt", sts_mabt, m_ma);
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic start(bit dn, bit posted);
    init_lock_n = 1'b0; init_frame_n = 1'b0;
    lk_start = 1'b1; lk_down = dn; lk_posted = posted;
    @(negedge clk);
    lk_start = 1'b0; init_frame_n = 1'b1;
  endtask

  task automatic done(logic [1:0] res, bit drop_lock);
    tgt_done = 1'b1; tgt_result = res;
    if (drop_lock) init_lock_n = 1'b1;
    @(negedge clk);
    tgt_done = 1'b0; tgt_result = 2'b00;
  endtask

  task automatic let_go(); init_lock_n = 1'b1; init_frame_n = 1'b1; endtask

  task automatic do_repeat();
    repeat_req = 1'b1; @(negedge clk); repeat_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("reset tgt_lock_n", tgt_lock_n, 1);
    chk("reset serr_n", serr_n, 1);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R11";
    init_lock_n = 1'b1;
    lk_start = 1'b1; lk_down = 1'b0; @(negedge clk); lk_start = 1'b0;
    idle(1);
    chk("upstream tgt_lock_n", tgt_lock_n, 1);

    cur_req = "R2";
    start(1'b1, 1'b0);
    chk("acquire tgt_lock_n", tgt_lock_n, 0);
    done(2'b00, 1'b0);
    cur_req = "R3";
    start(1'b1, 1'b0);
    done(2'b01, 1'b0);
    chk("later retry keeps lock", tgt_lock_n, 0);
    start(1'b1, 1'b0);
    done(2'b00, 1'b0);
    cur_req = "R4";
    let_go();
    idle(1);
    chk("release window start", tgt_lock_n, 0);
    idle(GAP);
    chk("release window end", tgt_lock_n, 1);
    idle(2);

    cur_req = "R3";
    start(1'b1, 1'b0);
    done(2'b01, 1'b0);
    chk("first retry drops lock", tgt_lock_n, 1);
    let_go(); idle(2);

    cur_req = "R5";
    start(1'b1, 1'b0);
    done(2'b00, 1'b0);
    start(1'b1, 1'b1);
    done(2'b00, 1'b1);
    chk("posted end drops lock", tgt_lock_n, 1);
    let_go(); idle(2);

    cur_req = "R7";
    start(1'b1, 1'b0);
    done(2'b10, 1'b0);
    chk("first abort frees", fwd_block, 0);
    idle(2);
    cur_req = "R6";
    repeat_req = 1'b1; #2;
    chk("abort return valid", abort_ret_vld, 1);
    chk("abort return code", abort_code, 2);
    @(negedge clk); repeat_req = 1'b0;
    let_go(); idle(2);

    cur_req = "R6";
    start(1'b1, 1'b0);
    done(2'b00, 1'b0);
    start(1'b1, 1'b0);
    done(2'b11, 1'b0);
    chk("later abort keeps lock", tgt_lock_n, 0);
    idle(1);
    do_repeat();
    let_go();
    idle(GAP + 3);
    chk("master abort status", sts_mabt, 1);

    cur_req = "R8";
    start(1'b1, 1'b0);
    done(2'b00, 1'b0);
    start(1'b1, 1'b1);
    done(2'b10, 1'b0);
    chk("serr pulse", serr_n, 0);
    idle(1);
    chk("serr one cycle", serr_n, 1);
    chk("lock kept", tgt_lock_n, 0);
    let_go(); idle(GAP + 3);

    cur_req = "R9";
    chk("ta sticky", sts_tabt, 1);
    sts_clr = 2'b01; @(negedge clk); sts_clr = 2'b00;
    chk("ta cleared", sts_tabt, 0);
    chk("ma untouched", sts_mabt, 1);
    sts_clr = 2'b10; @(negedge clk); sts_clr = 2'b00;
    chk("ma cleared", sts_mabt, 0);

    cur_req = "R10";
    start(1'b1, 1'b0);
    done(2'b00, 1'b0);
    let_go();
    idle(1);
    lk_start = 1'b1; lk_down = 1'b1; lk_posted = 1'b0;
    @(negedge clk); lk_start = 1'b0;
    idle(GAP - 1);
    chk("lock dropped before relaunch", tgt_lock_n, 1);
    idle(1);
    chk("held start relaunched", tgt_lock_n, 0);
    init_lock_n = 1'b0;
    done(2'b01, 1'b0);
    let_go(); idle(3);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule